// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit up-counter advanced by a programmable clock divider, with four compare channels. Each channel holds a 32-bit compare value and can, when the counter reaches it, freeze the timer, send the counter back to zero on its next step, and latch a sticky status flag. A status flag drives the single interrupt line when that channel's interrupt enable is set.

Software controls the block through a single-cycle register port: writes take effect on the next clock, reads return the addressed register combinationally. The control register starts and stops counting and can hold both counters at zero. The divider value can only be changed while counting is off, so a running count period is never disturbed. Everything runs on one clock with an active-low asynchronous reset.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, both counters are zero and irq_o is low.
- R2: With the enable bit (control bit 0) set and the hold bit (control bit 1) clear, the divider counter (address 3) steps 0..P, where P is the divider value (address 2), and the timer (address 1) advances by one each time the divider counter wraps, i.e. once every P+1 clocks.
- R3: A write to the divider value while the enable bit is set is ignored; the old value keeps reading back.
- R4: The match-control register (address 4) holds for channel k a reset-on-match bit at position 2k and a stop-on-match bit at position 2k+1; bits 31..8 always read zero.
- R5: With channel k's reset bit set (and its stop bit clear), the timer step taken while the timer equals compare value k loads zero instead of the incremented value, giving a period of (M+1)(P+1) clocks for compare value M.
- R6: With channel k's stop bit set, on the clock after the timer takes compare value k both counters hold their values and the enable bit clears.
- R7: When both stop and reset bits of a channel are set, the stop action wins: the timer stays at the compare value and, once re-enabled, continues to compare value plus one.
- R8: Status bit k (address 6, bit k) is set once each time the timer takes compare value k; writing 1 to a status bit clears it, writing 0 has no effect.
- R9: irq_o is high exactly when some status bit and its enable bit (address 5, bit k) are both set.
- R10: While the hold bit is set, the timer and divider counter are zero and no match is recorded.
- R11: Compare values k = 0..3 sit at addresses 8+k; the control register is address 0; unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed runs use divider values 0, 1, 3 and 9 so that the step rate, the wrap point of the divider counter and the position of a match inside a long divider period are each visible separately. Reset-on-match, stop-on-match and both together on one channel are run against the same compare value, which separates a frozen timer from one that wrapped or kept going. A long divider period lets the status flag be cleared while the timer still equals the compare value, showing a match is counted once and not per cycle. Random writes to every register interleaved with reads are then compared each cycle against a bench model.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_TC     = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_DIV    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_DCNT   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_MCTL   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CMP0   = 4'd8;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_HOLD_BIT = 1;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= tick_o ? '0 : cnt_q + ONE;
  end

  assert_div_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && cnt_q < limit_i) |=> cnt_q == $past(cnt_q) + ONE);
  assert_div_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tc_i,
  input  logic [W-1:0] cmp_i,
  input  logic         fresh_i,
  input  logic         stop_en_i,
  input  logic         wrap_en_i,
  input  logic         flag_clr_i,
  output logic         hit_o,
  output logic         stop_o,
  output logic         wrap_o,
  output logic         flag_o
);
  logic equal;
  logic flag_q;

  assign equal  = (tc_i == cmp_i);
  // a match counts only on the cycle the timer has just stepped
  assign hit_o  = fresh_i && equal;
  assign stop_o = hit_o && stop_en_i;
  // stop outranks reset, also after a resume
  assign wrap_o = equal && wrap_en_i && !stop_en_i;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (hit_o)       flag_q <= 1'b1;
    else if (flag_clr_i)  flag_q <= 1'b0;
  end

  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> flag_q);
  assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
  assert_flag_noset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !hit_o) |=> !flag_q);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned N_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o
);
  localparam int unsigned MC_W = 2 * N_CH;
  localparam logic [W-1:0] ONE = W'(1);

  logic            en_q, hold_q;
  logic [W-1:0]    div_q, tc_q, dcnt;
  logic [MC_W-1:0] mctl_q;
  logic [N_CH-1:0] ien_q;
  logic [W-1:0]    cmp_q [N_CH];
  logic [W-1:0]    cmp_rd [N_CH];
  logic            fresh_q;
  logic [N_CH-1:0] hit_v, stop_v, wrap_v, flag_v, clr_v;
  logic            stop_hit, wrap_any, run, tick;

  logic wr_ctrl, wr_div, wr_mctl, wr_ien, wr_stat;
  assign wr_ctrl = we_i && (addr_i == ADR_CTRL);
  assign wr_div  = we_i && (addr_i == ADR_DIV);
  assign wr_mctl = we_i && (addr_i == ADR_MCTL);
  assign wr_ien  = we_i && (addr_i == ADR_IEN);
  assign wr_stat = we_i && (addr_i == ADR_STAT);

  assign stop_hit = |stop_v;
  assign wrap_any = |wrap_v;
  assign run      = en_q && !hold_q && !stop_hit;

  mt_prescaler #(.W(W)) u_div (
    .clk_i, .rst_ni,
    .clr_i   (hold_q),
    .run_i   (run),
    .limit_i (div_q),
    .cnt_o   (dcnt),
    .tick_o  (tick)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] ADR_K = ADR_CMP0 + ADDR_W'(k);

    assign clr_v[k] = wr_stat && wdata_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cmp_q[k] <= '0;
      else if (we_i && addr_i == ADR_K)     cmp_q[k] <= wdata_i;
    end

    assign cmp_rd[k] = (addr_i == ADR_K) ? cmp_q[k] : '0;

    mt_match_chan #(.W(W)) u_ch (
      .clk_i, .rst_ni,
      .tc_i       (tc_q),
      .cmp_i      (cmp_q[k]),
      .fresh_i    (fresh_q),
      .stop_en_i  (mctl_q[2*k+1]),
      .wrap_en_i  (mctl_q[2*k]),
      .flag_clr_i (clr_v[k]),
      .hit_o      (hit_v[k]),
      .stop_o     (stop_v[k]),
      .wrap_o     (wrap_v[k]),
      .flag_o     (flag_v[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      hold_q  <= 1'b0;
      div_q   <= '0;
      mctl_q  <= '0;
      ien_q   <= '0;
      tc_q    <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[CTRL_EN_BIT];
        hold_q <= wdata_i[CTRL_HOLD_BIT];
      end
      if (stop_hit) en_q <= 1'b0;
      if (wr_div && !en_q) div_q <= wdata_i;
      if (wr_mctl) mctl_q <= wdata_i[MC_W-1:0];
      if (wr_ien)  ien_q  <= wdata_i[N_CH-1:0];
      if (hold_q)    tc_q <= '0;
      else if (tick) tc_q <= wrap_any ? '0 : tc_q + ONE;
      fresh_q <= tick;
    end
  end

  assign irq_o = |(flag_v & ien_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL: rdata_o = W'({hold_q, en_q});
      ADR_TC:   rdata_o = tc_q;
      ADR_DIV:  rdata_o = div_q;
      ADR_DCNT: rdata_o = dcnt;
      ADR_MCTL: rdata_o = W'(mctl_q);
      ADR_IEN:  rdata_o = W'(ien_q);
      ADR_STAT: rdata_o = W'(flag_v);
      default: begin
        for (int k = 0; k < N_CH; k++) rdata_o = rdata_o | cmp_rd[k];
      end
    endcase
  end

  assert_div_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(div_q));
  assert_stop_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_hit && !hold_q) |=> ($stable(tc_q) && $stable(dcnt) && !en_q));
  assert_hold_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |=> (tc_q == '0 && dcnt == '0 && !fresh_q));
  assert_tc_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !tick) |=> $stable(tc_q));
  assert_tc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && tick && !wrap_any) |=> tc_q == $past(tc_q) + ONE);
  assert_tc_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && tick && wrap_any) |=> tc_q == '0);
  assert_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  match_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- bench model ----------------
  logic        m_en, m_hold, m_fresh;
  logic [31:0] m_div, m_tc, m_dc;
  logic [7:0]  m_mc;
  logic [3:0]  m_ien, m_st;
  logic [31:0] m_cmp [4];
  logic [3:0]  t_hit;
  logic        t_stop, t_wrap, t_run, t_tick, t_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_hold <= 0; m_fresh <= 0; m_div <= 0; m_tc <= 0; m_dc <= 0;
      m_mc <= 0; m_ien <= 0; m_st <= 0;
      for (int k = 0; k < 4; k++) m_cmp[k] <= 0;
    end else begin
      t_hit = 0; t_stop = 0; t_wrap = 0;
      for (int k = 0; k < 4; k++) begin
        t_hit[k] = m_fresh && (m_tc == m_cmp[k]);
        if (t_hit[k] && m_mc[2*k+1]) t_stop = 1;
        if (m_tc == m_cmp[k] && m_mc[2*k] && !m_mc[2*k+1]) t_wrap = 1;
      end
      t_run  = m_en && !m_hold && !t_stop;
      t_tick = t_run && (m_dc == m_div);
      if (m_hold) begin m_dc <= 0; m_tc <= 0; end
      else begin
        if (t_run)  m_dc <= t_tick ? 32'd0 : m_dc + 32'd1;
        if (t_tick) m_tc <= t_wrap ? 32'd0 : m_tc + 32'd1;
      end
      m_fresh <= t_tick;
      t_en = m_en;
      if (we && addr == 4'd0) begin t_en = wdata[0]; m_hold <= wdata[1]; end
      if (t_stop) t_en = 0;
      m_en <= t_en;
      if (we && addr == 4'd2 && !m_en) m_div <= wdata;
      if (we && addr == 4'd4) m_mc <= wdata[7:0];
      if (we && addr == 4'd5) m_ien <= wdata[3:0];
      for (int k = 0; k < 4; k++)
        if (we && addr == 4'(8 + k)) m_cmp[k] <= wdata;
      m_st <= (m_st & ~((we && addr == 4'd6) ? wdata[3:0] : 4'd0)) | t_hit;
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {30'd0, m_hold, m_en};
      4'd1: return m_tc;
      4'd2: return m_div;
      4'd3: return m_dc;
      4'd4: return {24'd0, m_mc};
      4'd5: return {28'd0, m_ien};
      4'd6: return {28'd0, m_st};
      4'd8, 4'd9, 4'd10, 4'd11: return m_cmp[a[1:0]];
      default: return 32'd0;
    endcase
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 12; a++) begin rd(4'(a), v); chk("R1 reset reg", v, 32'd0); end
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R4 field layout
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, v); chk("R4 reserved bits", v, 32'h0000_00FF);
    wr(4'd4, 32'd0);

    // R2 divide by 4, R11 control address
    wr(4'd2, 32'd3); wr(4'd0, 32'd1);
    repeat (9) @(negedge clk);
    rd(4'd1, v); chk("R2 tc div4", v, 32'd2);
    rd(4'd3, v); chk("R2 divider count", v, 32'd1);
    rd(4'd0, v); chk("R11 ctrl readback", v, 32'd1);

    // R3 locked divider
    wr(4'd2, 32'd0); rd(4'd2, v); chk("R3 divider locked", v, 32'd3);

    // R10 hold
    wr(4'd0, 32'd3); repeat (5) @(negedge clk);
    rd(4'd1, v); chk("R10 tc held zero", v, 32'd0);
    rd(4'd3, v); chk("R10 div held zero", v, 32'd0);

    // R2 divide by 1
    wr(4'd0, 32'd2); wr(4'd2, 32'd0); wr(4'd0, 32'd1);
    repeat (6) @(negedge clk);
    rd(4'd1, v); chk("R2 tc every clock", v, 32'd6);

    // R5 reset-on-match, divider 1, compare 5
    wr(4'd0, 32'd2); wr(4'd2, 32'd1); wr(4'd8, 32'd5); wr(4'd4, 32'd1);
    wr(4'd6, 32'hF); wr(4'd0, 32'd1);
    repeat (11) @(negedge clk);
    rd(4'd1, v); chk("R5 tc at compare", v, 32'd5);
    repeat (2) @(negedge clk);
    rd(4'd1, v); chk("R5 tc wrapped", v, 32'd0);
    rd(4'd6, v); chk("R5 flag ch0", v & 32'd1, 32'd1);

    // R6 stop-on-match ch1 at 7
    wr(4'd0, 32'd2); wr(4'd6, 32'hF); wr(4'd4, 32'h8); wr(4'd9, 32'd7);
    wr(4'd2, 32'd0); wr(4'd0, 32'd1);
    repeat (20) @(negedge clk);
    rd(4'd1, v); chk("R6 tc frozen", v, 32'd7);
    rd(4'd3, v); chk("R6 div frozen", v, 32'd0);
    rd(4'd0, v); chk("R6 enable cleared", v, 32'd0);
    rd(4'd6, v); chk("R8 flags ch0 ch1", v, 32'd3);

    // R7 stop and reset on one channel
    wr(4'd6, 32'hF); wr(4'd4, 32'hC); wr(4'd0, 32'd2); wr(4'd0, 32'd1);
    repeat (20) @(negedge clk);
    rd(4'd1, v); chk("R7 stop wins", v, 32'd7);
    wr(4'd0, 32'd1);
    @(negedge clk);
    rd(4'd1, v); chk("R7 resume past compare", v, 32'd8);

    // R8/R9 flag once per occurrence, divider 9, compare2 = 3
    wr(4'd0, 32'd2); wr(4'd4, 32'd0); wr(4'd6, 32'hF); wr(4'd2, 32'd9);
    wr(4'd10, 32'd3); wr(4'd5, 32'd4); wr(4'd0, 32'd1);
    repeat (34) @(negedge clk);
    rd(4'd6, v); chk("R8 flag ch2", v, 32'd4);
    chk("R9 irq enabled flag", {31'd0, irq}, 32'd1);
    wr(4'd6, 32'd0); rd(4'd6, v); chk("R8 write zero no effect", v, 32'd4);
    wr(4'd6, 32'd4); rd(4'd6, v); chk("R8 w1c", v, 32'd0);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
    repeat (2) @(negedge clk);
    rd(4'd1, v); chk("R8 tc still at compare", v, 32'd3);
    rd(4'd6, v); chk("R8 once per occurrence", v, 32'd0);
    wr(4'd5, 32'd0);
    repeat (12) @(negedge clk);
    rd(4'd6, v); chk("R8 flag ch0 later", v, 32'd1);
    chk("R9 masked flag", {31'd0, irq}, 32'd0);

    // R11 compare readback
    rd(4'd10, v); chk("R11 compare2 addr", v, 32'd3);
    rd(4'd7, v);  chk("R11 unused addr", v, 32'd0);

    // random phase against model (R2 R5 R6 R7 R8 R9)
    wr(4'd0, 32'd2); wr(4'd6, 32'hF);
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] a;
      r = int'($urandom % 16);
      if (r < 3) begin
        case ($urandom % 9)
          0: begin a = 4'd0; wdata = (($urandom % 8) == 0) ? 32'd2 : ((($urandom % 8) == 0) ? 32'd0 : 32'd1); end
          1: begin a = 4'd2; wdata = $urandom % 3; end
          2: begin a = 4'd4; wdata = $urandom; end
          3: begin a = 4'd5; wdata = $urandom; end
          4: begin a = 4'd6; wdata = $urandom; end
          default: begin a = 4'(8 + ($urandom % 4)); wdata = $urandom % 12; end
        endcase
        we = 1'b1;
      end else begin
        a = 4'($urandom % 12);
        we = 1'b0;
      end
      addr = a; #1;
      chk("R2 R5 R6 R8 model read", rdata, m_read(a));
      chk("R9 model irq", {31'd0, irq}, {31'd0, |(m_st & m_ien)});
      @(negedge clk);
      we = 1'b0;
    end
    finish_run();
  end
endmodule